// File: doc/BRIEF.md
# Shared-Bus Master Requester

This block lets a local processor win and hand back ownership of a shared bus that has four prioritised request levels. Software picks which request line the requester drives and which release policy governs ownership. When the local side signals that it wants the bus, the block raises the chosen request line and waits for the grant on that same level. On the grant it drops the request, raises bus-busy and signals ownership to the local side, which may then run its transfers.

Ownership ends according to the policy that was latched when the request began. There are three policies. Under release-on-request, the bus stays with this master after a transfer until some other master raises a request line. Under release-when-done, the bus is given up as soon as a transfer completes. Under capture-and-hold, the bus stays until software releases it explicitly. The arbiter itself, the data cycles and the electrical drivers lie outside this block. A transfer is represented only by a one-cycle completion pulse.

Top module: `busreq_top`

## Requirements
- R1: During and right after reset, no request line is driven, bus-busy is low and the owned indication is low.
- R2: When the block is idle and `want_bus` is high at a clock edge, exactly one request line goes high after that edge. It is bit `cfg_level` of `req_out`, where level value n drives bit n.
- R3: Ownership begins only in the cycle after a grant on the selected level is seen while requesting. A grant on any other level, or any grant while idle, changes nothing.
- R4: A request line and bus-busy are never high together. The request is dropped in the same cycle that bus-busy rises.
- R5: The mode code 0 selects release-on-request. In this mode ownership survives completed transfers for as long as `other_req` is all zero. Once at least one transfer has completed and `other_req` is non-zero at an edge, ownership ends after that edge.
- R6: The mode code 1 selects release-when-done. A `xfer_done` pulse while owning ends ownership after that edge, whatever `other_req` shows.
- R7: The mode codes 2 and 3 select capture-and-hold. In these modes `xfer_done` and `other_req` have no effect, and ownership ends only after an edge with `sw_release` high.
- R8: Release takes exactly one cycle. In that cycle the owned indication is low while bus-busy is still high. Bus-busy falls on return to idle.
- R9: Level and mode are sampled only while the block is idle. Changes made while requesting or owning take effect from the next request onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 2 | Selected request level (0..3) |
| cfg_mode | input | 2 | Release policy code |
| want_bus | input | 1 | Local side asks for the bus |
| xfer_done | input | 1 | One-cycle pulse when a transfer completes |
| sw_release | input | 1 | Explicit software release for capture-and-hold |
| grant_in | input | 4 | Grant seen per level |
| other_req | input | 4 | Request lines of other masters |
| req_out | output | 4 | Request lines driven by this master |
| bbsy | output | 1 | Bus-busy driven by this master |
| owned | output | 1 | Local transfers may proceed |

## Verification
The bench builds the block with its default of four request levels, which gives a two-bit level field. At this size every request bit can be reached, and the selected-level grant can be set against a grant on another level. The bench runs all three release policies back to back. It changes level and mode while the block owns the bus, so the idle-only sampling shows up at the request lines of the following round.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_REL  = 2'd3
  } rq_state_e;

  localparam logic [1:0] MODE_ON_REQ  = 2'd0;
  localparam logic [1:0] MODE_ON_DONE = 2'd1;

  // Release decision for the current owned cycle.
  function automatic logic release_due(
    input logic [1:0] mode,
    input logic       done_now,
    input logic       done_before,
    input logic       others_pending,
    input logic       sw_rel
  );
    logic due;
    case (mode)
      MODE_ON_REQ:  due = others_pending && (done_now || done_before);
      MODE_ON_DONE: due = done_now;
      default:      due = sw_rel;
    endcase
    return due;
  endfunction

endpackage

// File: rtl/busreq_cfg.sv
module busreq_cfg #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [1:0]       mode_in,
  output logic [LVL_W-1:0] lvl_q,
  output logic [1:0]       mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      mode_q <= '0;
    end else if (capture) begin
      lvl_q  <= lvl_in;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/busreq_release.sv
module busreq_release
  import busreq_pkg::*;
#(
  parameter int NUM_LEVELS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_own,
  input  logic [1:0]            mode,
  input  logic                  xfer_done,
  input  logic [NUM_LEVELS-1:0] other_req,
  input  logic                  sw_release,
  output logic                  rel_now,
  output logic                  done_seen
);
  logic others_pending;
  assign others_pending = |other_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_seen <= 1'b0;
    else if (!in_own)   done_seen <= 1'b0;
    else if (xfer_done) done_seen <= 1'b1;
  end

  assign rel_now = in_own &&
                   release_due(mode, xfer_done, done_seen, others_pending, sw_release);
endmodule

// File: rtl/busreq_fsm.sv
module busreq_fsm
  import busreq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      want_bus,
  input  logic      grant_hit,
  input  logic      rel_now,
  output rq_state_e state
);
  rq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (want_bus)  nxt = ST_REQ;
      ST_REQ:  if (grant_hit) nxt = ST_OWN;
      ST_OWN:  if (rel_now)   nxt = ST_REL;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/busreq_top.sv
module busreq_top
  import busreq_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LVL_W-1:0]      cfg_level,
  input  logic [1:0]            cfg_mode,
  input  logic                  want_bus,
  input  logic                  xfer_done,
  input  logic                  sw_release,
  input  logic [NUM_LEVELS-1:0] grant_in,
  input  logic [NUM_LEVELS-1:0] other_req,
  output logic [NUM_LEVELS-1:0] req_out,
  output logic                  bbsy,
  output logic                  owned
);
  rq_state_e        state;
  logic [LVL_W-1:0] act_level;
  logic [1:0]       act_mode;
  logic             is_idle, is_req, in_own, grant_hit, rel_now, done_seen;

  assign is_idle   = (state == ST_IDLE);
  assign is_req    = (state == ST_REQ);
  assign in_own    = (state == ST_OWN);
  assign grant_hit = grant_in[act_level];

  busreq_cfg #(.LVL_W(LVL_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .capture(is_idle),
    .lvl_in(cfg_level), .mode_in(cfg_mode),
    .lvl_q(act_level), .mode_q(act_mode)
  );

  busreq_release #(.NUM_LEVELS(NUM_LEVELS)) rel_i (
    .clk(clk), .rst_n(rst_n), .in_own(in_own), .mode(act_mode),
    .xfer_done(xfer_done), .other_req(other_req), .sw_release(sw_release),
    .rel_now(rel_now), .done_seen(done_seen)
  );

  busreq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .want_bus(want_bus),
    .grant_hit(grant_hit), .rel_now(rel_now), .state(state)
  );

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_req
    assign req_out[g] = is_req && (act_level == g[LVL_W-1:0]);
  end

  assign bbsy  = in_own || (state == ST_REL);
  assign owned = in_own;
endmodule

// File: rtl/busreq_checker.sv
module busreq_checker #(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LEVELS-1:0] req_out,
  input logic                  bbsy,
  input logic                  owned,
  input logic [NUM_LEVELS-1:0] grant_in,
  input logic                  xfer_done,
  input logic                  sw_release,
  input logic [1:0]            act_mode,
  input logic [LVL_W-1:0]      act_level,
  input logic                  is_idle
);
  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_out));

  assert_req_bbsy_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((|req_out) && bbsy));

  assert_own_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned) |-> $past((grant_in & req_out) != '0));

  assert_rel_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owned) |-> bbsy);

  assert_bbsy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(owned) |=> !bbsy);

  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && act_mode == 2'd1 && xfer_done) |=> !owned);

  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && act_mode[1] && !sw_release) |=> owned);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_idle |=> ($stable(act_level) && $stable(act_mode)));
endmodule

bind busreq_top busreq_checker #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_out(req_out), .bbsy(bbsy), .owned(owned),
  .grant_in(grant_in), .xfer_done(xfer_done), .sw_release(sw_release),
  .act_mode(act_mode), .act_level(act_level), .is_idle(is_idle)
);

// File: tb/busreq_top_tb_top.sv
`timescale 1ns/1ps
module busreq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_level = '0, cfg_mode = '0;
  logic       want_bus = 1'b0, xfer_done = 1'b0, sw_release = 1'b0;
  logic [3:0] grant_in = '0, other_req = '0;
  logic [3:0] req_out;
  logic       bbsy, owned;

  int    errs = 0, checks = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  busreq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_mode(cfg_mode),
    .want_bus(want_bus), .xfer_done(xfer_done), .sw_release(sw_release),
    .grant_in(grant_in), .other_req(other_req),
    .req_out(req_out), .bbsy(bbsy), .owned(owned)
  );

  // Behavioural reference: phase 0 idle, 1 asking, 2 holding, 3 letting go.
  int phase = 0, m_lvl = 0, m_mode = 0;
  bit m_done = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; m_lvl = 0; m_mode = 0; m_done = 0;
    end else begin
      if (phase == 0) begin
        m_lvl = cfg_level; m_mode = cfg_mode; m_done = 0;
        if (want_bus) phase = 1;
      end else if (phase == 1) begin
        if (grant_in[m_lvl]) begin phase = 2; m_done = 0; end
      end else if (phase == 2) begin
        bit go;
        if (m_mode == 1)      go = xfer_done;
        else if (m_mode == 0) go = (other_req != 0) && (m_done || xfer_done);
        else                  go = sw_release;
        if (xfer_done) m_done = 1;
        if (go) phase = 3;
      end else phase = 0;
    end
  end

  function automatic logic [5:0] model_out();
    logic [3:0] r = (phase == 1) ? (4'b1 << m_lvl) : 4'b0;
    return {r, phase >= 2, phase == 2};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished)
    chk({cur_req, " model"}, {26'd0, req_out, bbsy, owned}, {26'd0, model_out()});

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset", {req_out, bbsy, owned}, 6'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", {req_out, bbsy, owned}, 6'd0);

    // Release-on-request at level 2
    cur_req = "R2"; cfg_level = 2; cfg_mode = 0; want_bus = 1;
    tick();
    chk("R2 level2 request", req_out, 4'b0100);
    cur_req = "R3"; grant_in = 4'b0001;
    tick(2);
    chk("R3 foreign grant ignored", {req_out, owned}, {4'b0100, 1'b0});
    grant_in = 4'b0100;
    tick();
    chk("R4 request dropped on ownership", {req_out, bbsy, owned}, {4'b0, 1'b1, 1'b1});
    grant_in = 0; cur_req = "R5";
    cfg_level = 0; cfg_mode = 1;          // ignored until idle (R9)
    xfer_done = 1; tick(); xfer_done = 0;
    tick(3);
    chk("R5 kept after done without rivals", owned, 1'b1);
    other_req = 4'b0010;
    tick();
    chk("R8 release cycle", {bbsy, owned}, 2'b10);
    tick();
    chk("R8 bbsy low in idle", {bbsy, owned}, 2'b00);
    other_req = 0; cur_req = "R9";
    tick();
    chk("R9 new level after idle", req_out, 4'b0001);

    // Release-when-done at level 0 (mode 1 latched)
    grant_in = 4'b0001; tick(); grant_in = 0;
    cur_req = "R6"; cfg_mode = 2; other_req = 4'b1000;
    tick();
    chk("R6 owned before done", owned, 1'b1);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R6 released on done", {bbsy, owned}, 2'b10);
    other_req = 0;
    tick(2);
    chk("R9 level unchanged", req_out, 4'b0001);

    // Capture-and-hold (mode 2 latched)
    cur_req = "R7"; grant_in = 4'b0001; tick(); grant_in = 0;
    xfer_done = 1; other_req = 4'b1110;
    tick(4);
    chk("R7 hold ignores done and rivals", owned, 1'b1);
    xfer_done = 0; sw_release = 1; want_bus = 0;
    tick();
    chk("R7 software release", {bbsy, owned}, 2'b10);
    sw_release = 0; other_req = 0;
    tick();

    // Grants while idle do nothing
    cur_req = "R3"; grant_in = 4'b1111;
    tick(3);
    chk("R3 idle grant ignored", {req_out, bbsy, owned}, 6'd0);
    grant_in = 0;
    tick(2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule